// File: doc/BRIEF.md
# Banked Memory Mapper with Disk ROM Trap

This block sits between an 8-bit CPU's 16-bit address bus and a memory system made of 128 KB of RAM, split into eight 16 KB pages, and a set of 16 KB ROMs. It divides the CPU address space into four 16 KB windows and translates each access into a physical selection.

- The highest window shows a RAM page chosen by software.
- The two middle windows are tied to fixed RAM pages.
- The lowest window is read-only and shows one ROM.

A single paging register, written through an I/O port, chooses the high RAM page, the display page and the normal ROM.

On top of register paging, the block watches opcode fetches and automatically swaps a disk-interface ROM into the lowest window. The swap-in happens when code is fetched from the 0x3D00–0x3DFF page while the BASIC ROM is showing. The swap-out happens when code is next fetched from RAM at 0x4000 or above. Both switches apply to the fetch that triggers them. The address translation is purely combinational, so there is no handshake and no back-pressure. Every access is resolved in the cycle it is presented, and only the paging register and the disk-ROM flag are clocked state.

Top module: `mem_mapper`

## Requirements
- R1: An I/O write whose 16-bit port address is 0x7FFD loads the 8-bit paging register from `io_data`; the new value is visible from the next clock cycle. I/O writes to any other port address leave the register unchanged.
- R2: For addresses 0xC000–0xFFFF, `ram_addr` is the paging register's bits 2:0 (page number) followed by `cpu_addr[13:0]`. `ram_sel` is high for any read, fetch or write there.
- R3: Addresses 0x4000–0x7FFF always map to RAM page 5, and 0x8000–0xBFFF always map to RAM page 2, whatever the paging register holds.
- R4: `disp_page` is 7 when paging register bit 3 is set and 5 when it is clear.
- R5: A read or fetch in 0x0000–0x3FFF raises `rom_sel` and presents `rom_addr` = `rom_idx` (2 bits) followed by `cpu_addr[13:0]`. With the disk ROM inactive, `rom_idx` equals paging register bit 4: index 0 is the 128K-mode ROM and index 1 is the BASIC ROM.
- R6: A write into 0x0000–0x3FFF asserts none of `ram_sel`, `ram_we` or `rom_sel`. A write at 0x4000 or above asserts `ram_sel` and `ram_we`.
- R7: Reset clears the paging register to 0 and leaves the disk ROM (index 3) active in the lowest window.
- R8: An opcode fetch with `cpu_addr[15:8]` = 0x3D while ROM index 1 is showing switches to disk ROM index 3. The fetch itself already reads from index 3, and the mapping persists afterwards.
- R9: An opcode fetch in 0x3D00–0x3DFF while ROM index 0 is showing does not enable the disk ROM.
- R10: While the disk ROM is active, an opcode fetch at 0x4000 or above disables it. From that same fetch on, `rom_idx` follows paging register bit 4.
- R11: Data reads never enable or disable the disk ROM, either inside 0x3D00–0x3DFF or at 0x4000 and above.
- R12: While the disk ROM is active, opcode fetches below 0x4000 keep it active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address (memory or I/O port) |
| fetch | input | 1 | Opcode-fetch read strobe |
| mem_rd | input | 1 | Data read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_wr | input | 1 | I/O write strobe |
| io_data | input | 8 | I/O write data byte |
| ram_sel | output | 1 | Access goes to RAM |
| ram_we | output | 1 | RAM write enable |
| rom_sel | output | 1 | Access goes to ROM |
| ram_addr | output | 17 | Physical RAM address |
| rom_idx | output | 2 | ROM currently mapped at the lowest window |
| rom_addr | output | 16 | ROM index followed by window offset |
| disp_page | output | 3 | RAM page used for display |

## Verification
Address translation, the select strobes and both trap switches are due in the same cycle the access is driven. The bench therefore drives each access after a falling edge and compares one time unit later, before the next rising edge. A paging-register write shows up only from the cycle after its rising edge, so the checks for its effects sit on the following access. The reference model applies the register and disk-flag updates just after each rising edge. This keeps the expected values always one edge behind the stimulus, matching the single register stage.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int ADDR_W  = 16;
  localparam int OFF_W   = 14;
  localparam int WIN_W   = ADDR_W - OFF_W;
  localparam int NWIN    = 1 << WIN_W;
  localparam int PAGE_W  = 3;
  localparam int ROM_IW  = 2;
  localparam int RAM_AW  = PAGE_W + OFF_W;
  localparam int ROM_AW  = ROM_IW + OFF_W;

  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [ROM_IW-1:0] rom_idx_t;

  typedef struct packed {
    logic  basic_sel;
    logic  disp_alt;
    page_t top_page;
  } page_fields_t;
endpackage

// File: rtl/mm_page_reg.sv
module mm_page_reg #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          PAGE_W    = 3,
  parameter logic [15:0] PORT_ADDR = 16'h7FFD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_port,
  input  logic [DATA_W-1:0] io_data,
  output logic [PAGE_W-1:0] top_page,
  output logic              disp_alt,
  output logic              basic_sel
);
  localparam int DISP_BIT  = PAGE_W;
  localparam int BASIC_BIT = PAGE_W + 1;

  logic [DATA_W-1:0] reg_q;
  logic              hit;

  assign hit = io_wr && (io_port == PORT_ADDR[ADDR_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n)   reg_q <= '0;
    else if (hit) reg_q <= io_data;
  end

  assign top_page  = reg_q[PAGE_W-1:0];
  assign disp_alt  = reg_q[DISP_BIT];
  assign basic_sel = reg_q[BASIC_BIT];
endmodule

// File: rtl/mm_rom_trap.sv
module mm_rom_trap #(
  parameter int       ADDR_W   = 16,
  parameter int       OFF_W    = 14,
  parameter int       ROM_IW   = 2,
  parameter logic [7:0] TRAP_HI = 8'h3D,
  parameter int       DISK_IDX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch,
  input  logic [ADDR_W-1:0] addr,
  input  logic              basic_sel,
  output logic [ROM_IW-1:0] rom_idx,
  output logic              disk_active
);
  localparam int HI_W = ADDR_W - 8;

  logic disk_q, enter, leave, disk_eff, in_low;

  assign in_low   = (addr[ADDR_W-1:OFF_W] == '0);
  assign enter    = fetch && !disk_q && basic_sel
                    && (addr[ADDR_W-1:8] == TRAP_HI[HI_W-1:0]);
  assign leave    = fetch && disk_q && !in_low;
  assign disk_eff = (disk_q && !leave) || enter;

  always_ff @(posedge clk) begin
    if (!rst_n) disk_q <= 1'b1;
    else        disk_q <= disk_eff;
  end

  assign disk_active = disk_eff;
  assign rom_idx     = disk_eff ? ROM_IW'(DISK_IDX) : ROM_IW'(basic_sel);
endmodule

// File: rtl/mm_decode.sv
module mm_decode #(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 14,
  parameter int PAGE_W  = 3,
  parameter int ROM_IW  = 2,
  parameter int FIXED_A = 5,
  parameter int FIXED_B = 2,
  parameter int DISP_LO = 5,
  parameter int DISP_HI = 7
) (
  input  logic                     [ADDR_W-1:0] addr,
  input  logic                                  fetch,
  input  logic                                  mem_rd,
  input  logic                                  mem_wr,
  input  logic                     [PAGE_W-1:0] top_page,
  input  logic                                  disp_alt,
  input  logic                     [ROM_IW-1:0] rom_idx,
  output logic                                  ram_sel,
  output logic                                  ram_we,
  output logic                                  rom_sel,
  output logic              [PAGE_W+OFF_W-1:0]  ram_addr,
  output logic              [ROM_IW+OFF_W-1:0]  rom_addr,
  output logic                     [PAGE_W-1:0] disp_page
);
  localparam int WIN_W = ADDR_W - OFF_W;
  localparam int NWIN  = 1 << WIN_W;

  logic [PAGE_W-1:0] win_page [NWIN];
  logic [WIN_W-1:0]  win;
  logic              low, rd_any;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    if (w == 1) begin : g_fa
      assign win_page[w] = PAGE_W'(FIXED_A);
    end else if (w == 2) begin : g_fb
      assign win_page[w] = PAGE_W'(FIXED_B);
    end else if (w == NWIN - 1) begin : g_top
      assign win_page[w] = top_page;
    end else begin : g_rom
      assign win_page[w] = '0;
    end
  end

  assign win     = addr[ADDR_W-1:OFF_W];
  assign low     = (win == '0);
  assign rd_any  = fetch || mem_rd;

  assign ram_sel   = !low && (rd_any || mem_wr);
  assign ram_we    = !low && mem_wr;
  assign rom_sel   = low && rd_any;
  assign ram_addr  = {win_page[win], addr[OFF_W-1:0]};
  assign rom_addr  = {rom_idx, addr[OFF_W-1:0]};
  assign disp_page = disp_alt ? PAGE_W'(DISP_HI) : PAGE_W'(DISP_LO);
endmodule

// File: rtl/mem_mapper.sv
module mem_mapper
  import mmap_pkg::*;
#(
  parameter logic [15:0] PORT_ADDR = 16'h7FFD,
  parameter logic [7:0]  TRAP_HI   = 8'h3D,
  parameter int          DISK_IDX  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              fetch,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              io_wr,
  input  logic [7:0]        io_data,
  output logic              ram_sel,
  output logic              ram_we,
  output logic              rom_sel,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [ROM_IW-1:0] rom_idx,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [PAGE_W-1:0] disp_page
);
  page_fields_t pf;
  logic         disk_active;

  mm_page_reg #(
    .ADDR_W(ADDR_W), .DATA_W(8), .PAGE_W(PAGE_W), .PORT_ADDR(PORT_ADDR)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(cpu_addr),
    .io_data(io_data), .top_page(pf.top_page), .disp_alt(pf.disp_alt),
    .basic_sel(pf.basic_sel)
  );

  mm_rom_trap #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ROM_IW(ROM_IW),
    .TRAP_HI(TRAP_HI), .DISK_IDX(DISK_IDX)
  ) u_trap (
    .clk(clk), .rst_n(rst_n), .fetch(fetch), .addr(cpu_addr),
    .basic_sel(pf.basic_sel), .rom_idx(rom_idx), .disk_active(disk_active)
  );

  mm_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W), .ROM_IW(ROM_IW)
  ) u_dec (
    .addr(cpu_addr), .fetch(fetch), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .top_page(pf.top_page), .disp_alt(pf.disp_alt), .rom_idx(rom_idx),
    .ram_sel(ram_sel), .ram_we(ram_we), .rom_sel(rom_sel),
    .ram_addr(ram_addr), .rom_addr(rom_addr), .disp_page(disp_page)
  );

  logic unused_disk;
  assign unused_disk = disk_active;
endmodule

// File: rtl/mem_mapper_chk.sv
module mem_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        fetch,
  input logic        mem_wr,
  input logic        io_wr,
  input logic [7:0]  io_data,
  input logic        ram_sel,
  input logic        ram_we,
  input logic        rom_sel,
  input logic [16:0] ram_addr,
  input logic [1:0]  rom_idx,
  input logic [2:0]  disp_page
);
  AST_LOW_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && cpu_addr < 16'h4000) |-> (!ram_we && !ram_sel && !rom_sel)); // R6

  AST_FIXED_PAGE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sel && cpu_addr[15:14] == 2'b01) |-> (ram_addr[16:14] == 3'd5)); // R3

  AST_PORT_DISP: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && cpu_addr == 16'h7FFD) |=> (disp_page == ($past(io_data[3]) ? 3'd7 : 3'd5))); // R4

  AST_HIGH_FETCH_NO_DISK: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && cpu_addr >= 16'h4000) |-> (rom_idx != 2'd3)); // R10

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch && !io_wr) ##1 !fetch |-> $stable(rom_idx)); // R11

  AST_IDX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rom_idx != 2'd2); // R5
endmodule

bind mem_mapper mem_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .fetch(fetch),
  .mem_wr(mem_wr), .io_wr(io_wr), .io_data(io_data), .ram_sel(ram_sel),
  .ram_we(ram_we), .rom_sel(rom_sel), .ram_addr(ram_addr),
  .rom_idx(rom_idx), .disp_page(disp_page)
);

// File: tb/tb_mem_mapper.sv
module tb_mem_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        fetch = 1'b0, mem_rd = 1'b0, mem_wr = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_data = '0;
  logic        ram_sel, ram_we, rom_sel;
  logic [16:0] ram_addr;
  logic [1:0]  rom_idx;
  logic [15:0] rom_addr;
  logic [2:0]  disp_page;

  int checks = 0, errors = 0;
  int m_pg = 0;
  bit m_disk = 1'b1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mem_mapper dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .fetch(fetch),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_wr(io_wr), .io_data(io_data),
    .ram_sel(ram_sel), .ram_we(ram_we), .rom_sel(rom_sel),
    .ram_addr(ram_addr), .rom_idx(rom_idx), .rom_addr(rom_addr),
    .disp_page(disp_page)
  );

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [15:0] a, bit f, bit rd, bit wr,
                      bit iow, logic [7:0] d);
    bit low, enter, leave, de;
    int idx, page;
    @(negedge clk);
    cpu_addr = a; fetch = f; mem_rd = rd; mem_wr = wr; io_wr = iow; io_data = d;
    #1;
    low   = (a < 16'h4000);
    enter = f && !m_disk && m_pg[4] && (a[15:8] == 8'h3D);
    leave = f && m_disk && !low;
    de    = (m_disk && !leave) || enter;
    idx   = de ? 3 : m_pg[4];
    case (a[15:14])
      2'd1:    page = 5;
      2'd2:    page = 2;
      2'd3:    page = m_pg & 7;
      default: page = 0;
    endcase
    cmp(tag, "rom_idx", rom_idx, idx);
    cmp(tag, "disp_page", disp_page, m_pg[3] ? 7 : 5);
    cmp(tag, "ram_sel", ram_sel, !low && (f || rd || wr));
    cmp(tag, "ram_we", ram_we, !low && wr);
    cmp(tag, "rom_sel", rom_sel, low && (f || rd));
    if (low) cmp(tag, "rom_addr", rom_addr, idx * 16384 + a[13:0]);
    else     cmp(tag, "ram_addr", ram_addr, page * 16384 + a[13:0]);
    @(posedge clk);
    #1;
    if (iow && a == 16'h7FFD) m_pg = d;
    m_disk = de;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R7: reset state, disk ROM active, paging register zero
    step("R7", 16'h0000, 0, 0, 0, 0, 8'h00);
    step("R7", 16'h0123, 0, 1, 0, 0, 8'h00);
    step("R12", 16'h0200, 1, 0, 0, 0, 8'h00);
    // R10: leave disk ROM on fetch from RAM
    step("R10", 16'h4000, 1, 0, 0, 0, 8'h00);
    step("R10", 16'h0040, 0, 1, 0, 0, 8'h00);
    // R9: trap page fetch with ROM 0 does nothing
    step("R9", 16'h3D10, 1, 0, 0, 0, 8'h00);
    step("R9", 16'h0010, 0, 1, 0, 0, 8'h00);
    // R1: port write loads register
    step("R1", 16'h7FFD, 0, 0, 0, 1, 8'h13);
    step("R2", 16'hC005, 0, 1, 0, 0, 8'h00);
    step("R5", 16'h1111, 0, 1, 0, 0, 8'h00);
    step("R1", 16'h7FFE, 0, 0, 0, 1, 8'h08);
    step("R1", 16'hFFFD, 0, 0, 0, 1, 8'h0C);
    step("R1", 16'hC100, 0, 1, 0, 0, 8'h00);
    // R4: display page select
    step("R4", 16'h7FFD, 0, 0, 0, 1, 8'h1F);
    step("R4", 16'hFFFF, 0, 1, 0, 0, 8'h00);
    // R3: fixed windows
    step("R3", 16'h4ABC, 0, 1, 0, 0, 8'h00);
    step("R3", 16'h8ABC, 1, 0, 0, 0, 8'h00);
    step("R3", 16'h5000, 0, 0, 1, 0, 8'h00);
    step("R3", 16'hBFFF, 0, 0, 1, 0, 8'h00);
    // R6: writes to low window blocked
    step("R6", 16'h1234, 0, 0, 1, 0, 8'h00);
    step("R6", 16'h3D00, 0, 0, 1, 0, 8'h00);
    // R11: data read in trap page does not enter
    step("R11", 16'h3D55, 0, 1, 0, 0, 8'h00);
    step("R11", 16'h0055, 0, 1, 0, 0, 8'h00);
    // R8: fetch in trap page with BASIC ROM enters
    step("R8", 16'h3D00, 1, 0, 0, 0, 8'h00);
    step("R8", 16'h0010, 0, 1, 0, 0, 8'h00);
    step("R12", 16'h0100, 1, 0, 0, 0, 8'h00);
    step("R12", 16'h3DFF, 1, 0, 0, 0, 8'h00);
    step("R11", 16'h8000, 0, 1, 0, 0, 8'h00);
    step("R11", 16'hC000, 0, 0, 1, 0, 8'h00);
    step("R11", 16'h0001, 0, 1, 0, 0, 8'h00);
    step("R10", 16'hC000, 1, 0, 0, 0, 8'h00);
    step("R10", 16'h2000, 0, 1, 0, 0, 8'h00);
    // R2: every top page
    for (int p = 0; p < 8; p++) begin
      step("R2", 16'h7FFD, 0, 0, 0, 1, 8'(p));
      step("R2", 16'hC000 + 16'(p * 257), 0, 0, 1, 0, 8'h00);
      step("R2", 16'hFF00, 0, 1, 0, 0, 8'h00);
    end
    // R7: reset again while disk inactive
    @(negedge clk); rst_n = 1'b0; fetch = 0; mem_rd = 0; mem_wr = 0; io_wr = 0;
    @(posedge clk); #1; m_pg = 0; m_disk = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    step("R7", 16'hC000, 0, 1, 0, 0, 8'h00);
    step("R7", 16'h0000, 0, 1, 0, 0, 8'h00);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule